// File: doc/BRIEF.md
# ADC Sample Output Encoder

This block sits between the digital back end of a sampling converter and its parallel output pins. Every clock it accepts one sample word (14 bits by default, 12 bits by parameter). It can apply two line codings that lower switching noise coupled back into the analog front end, and it can apply them separately or together:
- a randomizer, which XORs the least significant bit into every other bit;
- alternate line polarity, which inverts every odd-numbered output line.

The coded word then leaves in one of three static output modes. In full-rate parallel mode each bit has its own line. In the two double-data-rate modes, single-ended and differential, each line carries two bits, one per clock edge, on half as many lines. The output is modelled as two bit vectors, one for the rising-edge value and one for the falling-edge value of each line, plus a forwarded output clock and a flag that selects differential pads. All outputs are registered, so every mode has one clock of latency.

Top module: `adc_out_encoder`

## Requirements
- R1: While reset is asserted, on the next rising clock edge both line vectors and the differential flag are all zero.
- R2: With mode code 0 (full-rate parallel), line i carries coded bit i on both edges, so the rising and falling vectors are equal. The value appears one clock after the sample is presented.
- R3: With mode code 1 or 2 (DDR), line k for k below SAMPLE_W/2 carries coded bit 2k in the rising vector and coded bit 2k+1 in the falling vector, one clock after the sample.
- R4: In the DDR modes, lines SAMPLE_W/2 and above are driven low on both edges, whatever the polarity setting.
- R5: With the randomizer enabled, coded bit i for i at least 1 equals sample bit i XOR sample bit 0, and coded bit 0 equals sample bit 0.
- R6: With alternate polarity enabled, every active line with an odd line index (bit 0 of the index set) is inverted on both edges. In DDR modes this counts physical line indices, not sample bit indices. Even lines are not changed.
- R7: With both codings enabled, the randomizer is applied first and the inversion second.
- R8: Mode code 3 behaves exactly as mode code 0. The differential flag is 1 one clock after mode code 2 is presented and 0 for every other mode.
- R9: The output clock follows the block clock at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_i | input | 1 | Synchronous reset, active high |
| mode_i | input | 2 | Output mode: 0 full rate, 1 DDR single-ended, 2 DDR differential, 3 same as 0 |
| rand_en_i | input | 1 | Randomizer enable |
| pol_en_i | input | 1 | Alternate line polarity enable |
| sample_i | input | SAMPLE_W | Sample word, one per clock |
| line_rise_o | output | SAMPLE_W | Line values valid on the rising edge |
| line_fall_o | output | SAMPLE_W | Line values valid on the falling edge |
| diff_sel_o | output | 1 | Selects differential pad signalling |
| out_clk_o | output | 1 | Forwarded output clock |

## Verification
The stimulus includes codes just either side of midscale (0x1FFF and 0x2000), all zeros and all ones, and single walking bits, run through every combination of mode and the two enables:
- The midscale pair is the code change in which every bit flips. It exposes a randomizer that leaves bit 0 out of the XOR, and it exposes polarity applied to sample bit indices rather than to line indices.
- The walking bits show which line and which edge each sample bit reaches, so any swap of the rising and falling halves in DDR shows up.
- Seeded random words with random configurations change in every cycle. They check the one-clock latency and the ordering of randomizer before inversion against an independent bench model.

// File: rtl/adc_enc_pkg.sv
package adc_enc_pkg;

  typedef enum logic [1:0] {
    MODE_FULL     = 2'd0,
    MODE_DDR_SE   = 2'd1,
    MODE_DDR_DIFF = 2'd2,
    MODE_SPARE    = 2'd3
  } out_mode_e;

  // Two bits per line per cycle in the double-data-rate modes
  function automatic logic mode_is_ddr(input logic [1:0] m);
    return (m == MODE_DDR_SE) || (m == MODE_DDR_DIFF);
  endfunction

  function automatic logic mode_is_diff(input logic [1:0] m);
    return m == MODE_DDR_DIFF;
  endfunction

  // Polarity class of a physical line: odd index lines are the inverted set
  function automatic logic line_is_odd(input int unsigned idx);
    return idx[0];
  endfunction

endpackage

// File: rtl/adc_enc_scrambler.sv
module adc_enc_scrambler #(
  parameter int SAMPLE_W = 14
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                en_i,
  input  logic [SAMPLE_W-1:0] raw_i,
  output logic [SAMPLE_W-1:0] coded_o
);

  // Bit 0 is the key and always passes untouched
  assign coded_o[0] = raw_i[0];

  for (genvar i = 1; i < SAMPLE_W; i++) begin : g_mix
    assign coded_o[i] = raw_i[i] ^ (en_i & raw_i[0]);
  end

  // R5: the key bit is never altered
  assert_key_bit_kept_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    coded_o[0] == raw_i[0]);

  // R5: with the randomizer off the word passes through
  assert_bypass_when_off_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |-> coded_o == raw_i);

endmodule

// File: rtl/adc_enc_lane_map.sv
module adc_enc_lane_map #(
  parameter int SAMPLE_W = 14
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                ddr_i,
  input  logic [SAMPLE_W-1:0] word_i,
  output logic [SAMPLE_W-1:0] rise_o,
  output logic [SAMPLE_W-1:0] fall_o
);

  localparam int DDR_LINES = SAMPLE_W / 2;

  logic [SAMPLE_W-1:0] ddr_rise;
  logic [SAMPLE_W-1:0] ddr_fall;

  for (genvar k = 0; k < SAMPLE_W; k++) begin : g_line
    if (k < DDR_LINES) begin : g_used
      assign ddr_rise[k] = word_i[2*k];
      assign ddr_fall[k] = word_i[2*k+1];
    end else begin : g_idle
      assign ddr_rise[k] = 1'b0;
      assign ddr_fall[k] = 1'b0;
    end
  end

  assign rise_o = ddr_i ? ddr_rise : word_i;
  assign fall_o = ddr_i ? ddr_fall : word_i;

  // R4: upper lines carry nothing in the folded modes
  assert_idle_lines_low_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    ddr_i |-> ((rise_o >> DDR_LINES) == '0 && (fall_o >> DDR_LINES) == '0));

  // R3: line 0 carries bits 0 and 1 on its two edges
  assert_line0_pair_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    ddr_i |-> (rise_o[0] == word_i[0] && fall_o[0] == word_i[1]));

endmodule

// File: rtl/adc_enc_polarity.sv
module adc_enc_polarity #(
  parameter int SAMPLE_W = 14
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                en_i,
  input  logic                ddr_i,
  input  logic [SAMPLE_W-1:0] rise_i,
  input  logic [SAMPLE_W-1:0] fall_i,
  output logic [SAMPLE_W-1:0] rise_o,
  output logic [SAMPLE_W-1:0] fall_o
);

  import adc_enc_pkg::*;

  localparam int DDR_LINES = SAMPLE_W / 2;

  logic [SAMPLE_W-1:0] flip_mask;

  // Only active lines with odd index are inverted; idle lines stay low
  for (genvar k = 0; k < SAMPLE_W; k++) begin : g_mask
    if (line_is_odd(k)) begin : g_odd
      if (k < DDR_LINES) begin : g_always_live
        assign flip_mask[k] = en_i;
      end else begin : g_full_only
        assign flip_mask[k] = en_i & ~ddr_i;
      end
    end else begin : g_even
      assign flip_mask[k] = 1'b0;
    end
  end

  assign rise_o = rise_i ^ flip_mask;
  assign fall_o = fall_i ^ flip_mask;

  // R6: even line 0 is never inverted
  assert_even_line_kept_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    rise_o[0] == rise_i[0] && fall_o[0] == fall_i[0]);

  // R6: line 1 is inverted whenever the coding is on
  assert_odd_line_flipped_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    en_i |-> (rise_o[1] != rise_i[1] && fall_o[1] != fall_i[1]));

endmodule

// File: rtl/adc_out_encoder.sv
module adc_out_encoder #(
  parameter int SAMPLE_W = 14
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic [1:0]          mode_i,
  input  logic                rand_en_i,
  input  logic                pol_en_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic [SAMPLE_W-1:0] line_rise_o,
  output logic [SAMPLE_W-1:0] line_fall_o,
  output logic                diff_sel_o,
  output logic                out_clk_o
);

  import adc_enc_pkg::*;

  logic                ddr_sel;
  logic [SAMPLE_W-1:0] coded_word;
  logic [SAMPLE_W-1:0] mapped_rise;
  logic [SAMPLE_W-1:0] mapped_fall;
  logic [SAMPLE_W-1:0] pol_rise;
  logic [SAMPLE_W-1:0] pol_fall;
  logic                ddr_q;

  assign ddr_sel = mode_is_ddr(mode_i);

  adc_enc_scrambler #(.SAMPLE_W(SAMPLE_W)) scr_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .en_i    (rand_en_i),
    .raw_i   (sample_i),
    .coded_o (coded_word)
  );

  adc_enc_lane_map #(.SAMPLE_W(SAMPLE_W)) map_i (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .ddr_i  (ddr_sel),
    .word_i (coded_word),
    .rise_o (mapped_rise),
    .fall_o (mapped_fall)
  );

  adc_enc_polarity #(.SAMPLE_W(SAMPLE_W)) pol_i (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .en_i   (pol_en_i),
    .ddr_i  (ddr_sel),
    .rise_i (mapped_rise),
    .fall_i (mapped_fall),
    .rise_o (pol_rise),
    .fall_o (pol_fall)
  );

  // Single output register stage: every mode has one clock of latency
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      line_rise_o <= '0;
      line_fall_o <= '0;
      diff_sel_o  <= 1'b0;
      ddr_q       <= 1'b0;
    end else begin
      line_rise_o <= pol_rise;
      line_fall_o <= pol_fall;
      diff_sel_o  <= mode_is_diff(mode_i);
      ddr_q       <= ddr_sel;
    end
  end

  assign out_clk_o = clk_i;

  // R1: reset clears the line registers on the following edge
  assert_reset_clears_R1: assert property (@(posedge clk_i)
    rst_i |=> (line_rise_o == '0 && line_fall_o == '0 && !diff_sel_o));

  // R2: full-rate lines hold one value for the whole cycle
  assert_full_edges_equal_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    !ddr_q |-> line_rise_o == line_fall_o);

  // R8: differential pads are only selected in a folded mode
  assert_diff_implies_ddr_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    diff_sel_o |-> ddr_q);

  // R2: key bit reaches line 0 one clock later in full-rate mode
  assert_full_latency_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    !ddr_sel |=> line_rise_o[0] == $past(sample_i[0]));

endmodule

// File: tb/adc_out_encoder_tb.sv
module adc_out_encoder_tb_top;

  localparam int W  = 14;
  localparam int HL = W / 2;

  logic         clk = 1'b0;
  logic         rst;
  logic [1:0]   mode;
  logic         rnd;
  logic         pol;
  logic [W-1:0] smp;
  logic [W-1:0] rise;
  logic [W-1:0] fall;
  logic         dsel;
  logic         oclk;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  adc_out_encoder #(.SAMPLE_W(W)) dut_i (
    .clk_i(clk), .rst_i(rst), .mode_i(mode), .rand_en_i(rnd), .pol_en_i(pol),
    .sample_i(smp), .line_rise_o(rise), .line_fall_o(fall),
    .diff_sel_o(dsel), .out_clk_o(oclk)
  );

  // Bench model of the coded word: bit 0 is the key
  function automatic logic [W-1:0] model_code(input logic [W-1:0] s, input logic r);
    logic [W-1:0] w = s;
    if (r) for (int i = 1; i < W; i++) w[i] = s[i] ^ s[0];
    return w;
  endfunction

  function automatic logic m_ddr(input logic [1:0] m);
    return m == 2'd1 || m == 2'd2;
  endfunction

  function automatic logic [W-1:0] model_edge(input logic [W-1:0] s, input logic [1:0] m,
                                              input logic r, input logic p, input logic falling);
    logic [W-1:0] w = model_code(s, r);
    logic [W-1:0] o = '0;
    if (m_ddr(m)) begin
      for (int k = 0; k < HL; k++) begin
        o[k] = falling ? w[2*k+1] : w[2*k];
        if (p && (k % 2 == 1)) o[k] = ~o[k];
      end
    end else begin
      for (int k = 0; k < W; k++) o[k] = (p && (k % 2 == 1)) ? ~w[k] : w[k];
    end
    return o;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive at negedge, sample just before the following negedge
  task automatic apply(input logic [1:0] m, input logic r, input logic p,
                       input logic [W-1:0] s, input string tag);
    @(negedge clk);
    mode = m; rnd = r; pol = p; smp = s;
    @(posedge clk);
    #1;
    check(tag, rise, model_edge(s, m, r, p, 1'b0));
    check(tag, fall, model_edge(s, m, r, p, 1'b1));
    check("R8", {{(W-1){1'b0}}, dsel}, {{(W-1){1'b0}}, m == 2'd2});
    if (m_ddr(m)) check("R4", (rise >> HL) | (fall >> HL), '0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [W-1:0] rv;
    void'($urandom(32'd1357));
    rst = 1'b1; mode = 2'd0; rnd = 1'b0; pol = 1'b0; smp = '1;
    repeat (3) @(posedge clk);
    #1;
    check("R1", rise, '0);
    check("R1", fall, '0);
    check("R1", {{(W-1){1'b0}}, dsel}, '0);
    @(negedge clk); rst = 1'b0;

    // R9: forwarded clock tracks clk on both phases
    @(posedge clk); #0.5;
    check("R9", {{(W-1){1'b0}}, oclk}, {{(W-1){1'b0}}, clk});
    @(negedge clk); #0.5;
    check("R9", {{(W-1){1'b0}}, oclk}, {{(W-1){1'b0}}, clk});

    // Directed corners across every mode and enable combination
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 4; c++) begin
        string tg;
        tg = (c == 3) ? "R7" : (c == 2) ? "R6" : (c == 1) ? "R5" :
             (m_ddr(m[1:0]) ? "R3" : (m == 3 ? "R8" : "R2"));
        apply(m[1:0], c[0], c[1], 14'h1FFF, tg);
        apply(m[1:0], c[0], c[1], 14'h2000, tg);
        apply(m[1:0], c[0], c[1], '0, tg);
        apply(m[1:0], c[0], c[1], '1, tg);
        for (int b = 0; b < W; b++) apply(m[1:0], c[0], c[1], W'(1) << b, tg);
      end
    end

    // R5 key bit: known pattern 0x0001 randomized in full mode gives all ones
    apply(2'd0, 1'b1, 1'b0, 14'h0001, "R5");
    check("R5", rise, 14'h3FFF);
    // R6 on line index in DDR: all-zero word, line 1 and 3 and 5 high, line 7+ low
    apply(2'd1, 1'b0, 1'b1, 14'h0000, "R6");
    check("R6", rise, 14'h002A);
    // R7 order: 0x0001 randomized then inverted in full mode -> even bits 1, odd 0
    apply(2'd0, 1'b1, 1'b1, 14'h0001, "R7");
    check("R7", rise, 14'h1555);

    // Seeded random traffic, configuration changing every sample
    for (int n = 0; n < 1500; n++) begin
      logic [1:0] m;
      m  = 2'($urandom);
      rv = W'($urandom);
      apply(m, 1'($urandom), 1'($urandom), rv, m_ddr(m) ? "R3" : "R2");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule